// File: doc/BRIEF.md
# Additive Checksum Checker and Repairer

This block runs an integrity check on the leading region of a word-addressed non-volatile memory, and it can also repair that check. The region ends at a fixed checksum slot, whose index is a parameter with a default of 63. The block reads the region one word at a time over a simple request/response port and keeps a running 16-bit sum that wraps modulo 2^16. The integrity rule is that the region sums to the signature value 0xBABA, not to zero.

A one-cycle `start` pulse begins an operation. If `mode_upd` is 0 when `start` is sampled, the block validates: it reads every word from address 0 up to the checksum slot, that slot included, and reports pass or fail. If `mode_upd` is 1, the block repairs: it sums only the words below the slot, then makes one write that stores the signature minus that partial sum into the slot. A read response that carries an error ends the operation at once. A write response that carries an error is reported. The serial link to the memory device is handled elsewhere.

Top module: `cksum_engine`

## Requirements
- R1: Validate mode reads addresses 0, 1, ... CSUM_IDX in ascending order, one request for each address, and makes no write.
- R2: At the end of a validate run, `done` comes with `pass`=1 when the 16-bit wrapped sum of the words read equals 0xBABA. Otherwise `pass`=0. In both cases `err`=0.
- R3: Update mode reads only addresses 0 to CSUM_IDX-1, in ascending order.
- R4: Update mode makes exactly one write, with `mem_we`=1 and address CSUM_IDX. The data written is 0xBABA minus the partial sum, modulo 2^16. When the write completes without error, `done` comes with `pass`=1 and `err`=0, and a later validate run passes.
- R5: A read response with `mem_err`=1 aborts the run. No further request is issued, and on the next cycle `done`=1, `err`=1 and `pass`=0.
- R6: A write response with `mem_err`=1 gives `done`=1, `err`=1 and `pass`=0 on the next cycle.
- R7: `done` is high for exactly one cycle per run, on the cycle after the last response. `pass` and `err` are 0 whenever `done` is 0.
- R8: A transfer completes on a cycle where `mem_req` and `mem_ack` are both 1. Until that cycle, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R9: A `start` pulse that arrives while a run is in progress is ignored. It does not change the mode, the addresses read, or the number of `done` pulses.
- R10: Synchronous active-high reset drops `mem_req` and `done` and returns the block to idle, including in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| mode_upd | input | 1 | 0 = validate, 1 = update (sampled with start) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Word address of request |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Response for the current request |
| mem_err | input | 1 | Response carries an error (valid with mem_ack) |
| mem_rdata | input | DATA_W | Read data (valid with mem_ack) |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Check passed / write stored (valid with done) |
| err | output | 1 | Memory port error (valid with done) |

## Verification
If the address counter is corrupted, the memory sees an out-of-order or duplicated read address on the next request. A wrong limit comparison shows up as an extra read or a missing read, or as a write that reaches the wrong slot, and it appears at the end of the run. A damaged accumulator never appears until `done`, where it gives a wrong `pass` or a wrong written word. For that reason the bench compares each run's sum with one computed from the memory image. A stuck state machine shows up as a missing `done`, or as a request still held after an error response.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
  typedef enum logic [1:0] {
    CK_IDLE  = 2'd0,
    CK_READ  = 2'd1,
    CK_WRITE = 2'd2
  } ck_state_e;

  localparam int unsigned CK_WORD_W    = 16;
  localparam logic [15:0] CK_SIGNATURE = 16'hBABA;
endpackage

// File: rtl/cksum_accum.sv
// Running modulo-2^DATA_W sum of the words returned by the memory.
module cksum_accum #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] next_sum
);
  logic [DATA_W-1:0] sum_q;

  // Sum as it stands once the word on din has been included.
  assign next_sum = sum_q + din;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum_q <= '0;
    end else if (add) begin
      sum_q <= next_sum;
    end
  end
endmodule

// File: rtl/cksum_ctrl.sv
// Sequencer: walks the address range, drives the memory port and
// produces the registered completion flags.
module cksum_ctrl
  import cksum_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CSUM_IDX  = 63,
  parameter logic [DATA_W-1:0] SIGNATURE = DATA_W'(CK_SIGNATURE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_upd,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] next_sum,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              acc_clr,
  output logic              acc_add,
  output logic              done,
  output logic              pass,
  output logic              err
);
  localparam logic [ADDR_W-1:0] SLOT      = ADDR_W'(CSUM_IDX);
  localparam bit                SLOT_ZERO = (CSUM_IDX == 0);

  ck_state_e         state_q;
  logic              upd_q;
  logic              req_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q, pass_q, err_q;
  logic [ADDR_W-1:0] last_addr;
  logic              xfer;

  // Update mode stops one word short of the checksum slot.
  assign last_addr = upd_q ? (SLOT - 1'b1) : SLOT;
  assign xfer      = req_q & mem_ack;

  assign acc_clr = (state_q == CK_IDLE) & start;
  assign acc_add = (state_q == CK_READ) & xfer & ~mem_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CK_IDLE;
      upd_q   <= 1'b0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        CK_IDLE: begin
          if (start) begin
            upd_q <= mode_upd;
            req_q <= 1'b1;
            if (mode_upd && SLOT_ZERO) begin
              // No words precede the slot: store the signature directly.
              state_q <= CK_WRITE;
              we_q    <= 1'b1;
              addr_q  <= SLOT;
              wdata_q <= SIGNATURE;
            end else begin
              state_q <= CK_READ;
              we_q    <= 1'b0;
              addr_q  <= '0;
            end
          end
        end
        CK_READ: begin
          if (xfer) begin
            if (mem_err) begin
              req_q   <= 1'b0;
              state_q <= CK_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
            end else if (addr_q == last_addr) begin
              if (upd_q) begin
                state_q <= CK_WRITE;
                we_q    <= 1'b1;
                addr_q  <= SLOT;
                wdata_q <= SIGNATURE - next_sum;
              end else begin
                req_q   <= 1'b0;
                state_q <= CK_IDLE;
                done_q  <= 1'b1;
                pass_q  <= (next_sum == SIGNATURE);
              end
            end else begin
              addr_q <= addr_q + 1'b1;
            end
          end
        end
        CK_WRITE: begin
          if (xfer) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            state_q <= CK_IDLE;
            done_q  <= 1'b1;
            err_q   <= mem_err;
            pass_q  <= ~mem_err;
          end
        end
        default: state_q <= CK_IDLE;
      endcase
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign done      = done_q;
  assign pass      = pass_q;
  assign err       = err_q;
endmodule

// File: rtl/cksum_engine.sv
module cksum_engine
  import cksum_pkg::*;
#(
  parameter int unsigned DATA_W   = CK_WORD_W,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CSUM_IDX = 63,
  parameter logic [DATA_W-1:0] SIGNATURE = DATA_W'(CK_SIGNATURE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_upd,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              pass,
  output logic              err
);
  logic              acc_clr, acc_add;
  logic [DATA_W-1:0] next_sum;

  cksum_accum #(.DATA_W(DATA_W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .clr      (acc_clr),
    .add      (acc_add),
    .din      (mem_rdata),
    .next_sum (next_sum)
  );

  cksum_ctrl #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CSUM_IDX  (CSUM_IDX),
    .SIGNATURE (SIGNATURE)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode_upd  (mode_upd),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .next_sum  (next_sum),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .acc_clr   (acc_clr),
    .acc_add   (acc_add),
    .done      (done),
    .pass      (pass),
    .err       (err)
  );
endmodule

// File: rtl/cksum_engine_chk.sv
module cksum_engine_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CSUM_IDX = 63
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              done,
  input logic              pass,
  input logic              err
);
  localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(CSUM_IDX);

  assert_addr_range_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr <= SLOT);

  assert_write_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_addr == SLOT);

  assert_read_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we && mem_err) |=> (!mem_req && done && err && !pass));

  assert_write_err_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_we && mem_err) |=> (done && err && !pass));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_quiet_flags_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!pass && !err));

  assert_hold_req_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!mem_req && !done));
endmodule

bind cksum_engine cksum_engine_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .CSUM_IDX (CSUM_IDX)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .mem_err   (mem_err),
  .done      (done),
  .pass      (pass),
  .err       (err)
);

// File: tb/tb_cksum_engine.sv
module tb_cksum_engine;
  localparam int unsigned DW   = 16;
  localparam int unsigned AW   = 8;
  localparam int unsigned IDX  = 63;
  localparam logic [15:0] SIG  = 16'hBABA;

  // Vector layout: {update, fix_image, latency[1:0], seed[15:0]}
  localparam int NV = 6;
  localparam logic [19:0] VECS [0:NV-1] = '{
    {1'b0, 1'b1, 2'd0, 16'h1234},
    {1'b0, 1'b0, 2'd1, 16'h0F0F},
    {1'b1, 1'b0, 2'd2, 16'hA5A5},
    {1'b0, 1'b1, 2'd3, 16'h7777},
    {1'b1, 1'b0, 2'd0, 16'hFFFF},
    {1'b0, 1'b0, 2'd1, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          mode_upd = 1'b0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic          mem_err = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          done, pass, err;

  always #5 clk = ~clk;

  cksum_engine #(.DATA_W(DW), .ADDR_W(AW), .CSUM_IDX(IDX)) dut (
    .clk(clk), .rst(rst), .start(start), .mode_upd(mode_upd),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .done(done), .pass(pass), .err(err)
  );

  // Memory model, acting on the falling edge.
  logic [DW-1:0] mem [0:255];
  int  lat = 0, wcnt = 0;
  int  reads = 0, writes = 0, exp_next = 0, order_bad = 0, done_cnt = 0;
  bit  rd_err_en = 0, wr_err_en = 0;
  int  rd_err_addr = 0;
  logic [AW-1:0] wr_addr_seen = '0;
  logic [DW-1:0] wr_data_seen = '0;

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req && !rst) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          writes++;
          wr_addr_seen = mem_addr;
          wr_data_seen = mem_wdata;
          if (wr_err_en) mem_err = 1'b1;
          else mem[mem_addr] = mem_wdata;
        end else begin
          reads++;
          if (int'(mem_addr) != exp_next) order_bad++;
          exp_next++;
          mem_rdata = mem[mem_addr];
          if (rd_err_en && int'(mem_addr) == rd_err_addr) mem_err = 1'b1;
        end
      end
    end else begin
      wcnt = 0;
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [15:0] seed);
    for (int i = 0; i < 256; i++)
      mem[i] = (seed + 16'(i) * 16'h0F1D) ^ {8'(i), 8'h00};
  endtask

  function automatic logic [15:0] sum_to(input int last);
    logic [15:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic clear_counts();
    reads = 0; writes = 0; exp_next = 0; order_bad = 0; done_cnt = 0;
  endtask

  // Launches one run and waits for done; returns flags seen with done.
  task automatic run_op(input bit upd, output bit got, output bit p, output bit e);
    int cycles;
    clear_counts();
    @(negedge clk);
    start = 1'b1; mode_upd = upd;
    @(negedge clk);
    start = 1'b0; mode_upd = 1'b0;
    cycles = 0;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
    got = done; p = pass; e = err;
    @(negedge clk);
    check(!done, "R7", "done width", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit got, p, e;
    logic [15:0] exp_w;
    fill(16'h0);
    repeat (3) @(negedge clk);
    check(!mem_req && !done && !pass && !err, "R10", "reset outputs",
          {mem_req, done, pass, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_req && !done, "R10", "idle after reset", {mem_req, done}, 0);

    // Table-driven runs
    for (int v = 0; v < NV; v++) begin
      fill(VECS[v][15:0]);
      lat = int'(VECS[v][17:16]);
      if (VECS[v][18]) mem[IDX] = SIG - sum_to(IDX - 1);
      if (!VECS[v][19]) begin
        run_op(1'b0, got, p, e);
        check(got, "R7", "validate done", int'(got), 1);
        check(p == (sum_to(IDX) == SIG) && !e, "R2", "validate verdict",
              {p, e}, {(sum_to(IDX) == SIG), 1'b0});
        check(reads == IDX + 1 && writes == 0 && order_bad == 0, "R1",
              "validate reads", reads, IDX + 1);
      end else begin
        exp_w = SIG - sum_to(IDX - 1);
        run_op(1'b1, got, p, e);
        check(got && p && !e, "R4", "update flags", {got, p, e}, 3'b110);
        check(reads == IDX && order_bad == 0, "R3", "update reads", reads, IDX);
        check(writes == 1 && wr_addr_seen == AW'(IDX), "R4", "write count/addr",
              writes, 1);
        check(wr_data_seen == exp_w, "R4", "write data", wr_data_seen, exp_w);
        run_op(1'b0, got, p, e);
        check(p && !e, "R4", "validate after update", {p, e}, 2'b10);
      end
    end

    // Wrap-around: all ones with a matching slot
    lat = 0;
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    mem[IDX] = 16'hBAF9;
    run_op(1'b0, got, p, e);
    check(p && !e, "R2", "modulo wrap pass", {p, e}, 2'b10);
    mem[IDX] = 16'hBAF8;
    run_op(1'b0, got, p, e);
    check(!p && !e, "R2", "off-by-one fail", {p, e}, 0);

    // Read error in validate mode at address 5
    fill(16'h4242);
    rd_err_en = 1; rd_err_addr = 5; lat = 1;
    run_op(1'b0, got, p, e);
    check(got && e && !p, "R5", "read error flags", {got, p, e}, 3'b101);
    repeat (5) @(negedge clk);
    check(reads == 6 && writes == 0 && !mem_req, "R5", "abort reads", reads, 6);

    // Read error at address 0 in update mode: no write follows
    rd_err_addr = 0;
    run_op(1'b1, got, p, e);
    repeat (5) @(negedge clk);
    check(e && !p && reads == 1 && writes == 0, "R5", "update abort writes",
          writes, 0);
    rd_err_en = 0;

    // Write error
    wr_err_en = 1;
    run_op(1'b1, got, p, e);
    check(got && e && !p && writes == 1, "R6", "write error flags",
          {got, p, e}, 3'b101);
    wr_err_en = 0;

    // Start during a run is ignored
    fill(16'h5151); lat = 0;
    clear_counts();
    @(negedge clk); start = 1'b1; mode_upd = 1'b0;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; mode_upd = 1'b1;
    @(negedge clk); start = 1'b0; mode_upd = 1'b0;
    repeat (300) @(negedge clk);
    check(reads == IDX + 1 && writes == 0, "R9", "restart ignored reads",
          reads, IDX + 1);
    check(done_cnt == 1, "R9", "single done", done_cnt, 1);

    // Reset in the middle of a run
    lat = 2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!mem_req && !done, "R10", "mid-run reset", {mem_req, done}, 0);
    rst = 1'b0;
    lat = 0;
    fill(16'h0101);
    mem[IDX] = SIG - sum_to(IDX - 1);
    run_op(1'b0, got, p, e);
    check(got && p && !e && reads == IDX + 1, "R10", "run after reset",
          reads, IDX + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule